// File: doc/BRIEF.md
# Write Burst Data Launcher

This block is the controller-side write data path of a double-data-rate memory controller. When a write command is accepted, it captures eight data words with their byte masks from the user side, one per cycle. It then replays them towards the pads after the programmed write latency. Around each burst it adds the strobe preamble and postamble.

The model runs on a single clock at the beat rate, so one memory clock equals two cycles of `clk`. Because of this, every latency given in memory clocks appears here doubled. The strobe is brought out as an enable plus a per-beat toggle flag rather than a real double-data-rate pin.

The write latency is the sum of a CAS write latency and an additive latency, both taken from configuration pins when the command is accepted. A second command exactly one burst slot after the previous one extends the stream without a gap. An eight-beat slot may be chopped to four valid beats.

Top module: `ddr3_wr_launcher`

## Requirements
- R1: With `cfg_cwl` = CWL and `cfg_al_sel` coding the additive latency AL (0: AL=0, 1: AL=CWL-1, 2: AL=CWL-2), WL = CWL + AL. For a command sampled at clock edge E0, the first data beat is on the outputs after edge E(2·WL-1), that is 2·WL cycles after the command cycle.
- R2: The eight words on `wr_data` in the command cycle and the seven cycles after it appear on `dq_out` in that order, on eight successive cycles with `dqs_toggle` high.
- R3: The two cycles directly before the first beat of a burst that does not follow another burst have `dqs_oe`=1, `dqs_toggle`=0 and `dq_oe`=0. The cycle before those two is idle.
- R4: After the last beat of the final burst of a chain there is one cycle with `dqs_oe`=1, `dqs_toggle`=0 and `dq_oe`=0. After that, the block is idle.
- R5: On a valid beat, `dm_out` carries the `wr_mask` bits captured with that word. A bit at 1 blocks the write of its byte, and a bit at 0 lets it complete.
- R6: With `cfg_chop`=1 at the command, `dqs_toggle` is still high for all eight beats. Only the first four beats have `dq_oe`=1. The last four have `dq_out`=0 and `dm_out` all ones.
- R7: A burst cannot be interrupted. A command arriving less than 8 cycles after an accepted command is ignored, and the running burst is output unchanged.
- R8: When idle (`dqs_oe`=0), `dq_oe`, `dq_out` and `dm_out` are all 0. Input words outside a capture window are never output.
- R9: A command accepted exactly 8 cycles after the previous one with the same WL puts its first beat on the cycle right after the previous burst's last beat. There is no postamble or preamble between the two bursts.
- R10: A command with `cfg_cwl` outside 5..8 or `cfg_al_sel`=3 is not launched. `cfg_err` is high for the one cycle after it.
- R11: After reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Beat-rate clock (two cycles per memory clock) |
| rst | input | 1 | Synchronous active-high reset |
| cfg_cwl | input | CWL_W | CAS write latency in memory clocks |
| cfg_al_sel | input | 2 | Additive latency code: 0 none, 1 CWL-1, 2 CWL-2, 3 illegal |
| cfg_chop | input | 1 | Four-beat chop for this command |
| wr_cmd | input | 1 | Write command strobe, one cycle |
| wr_data | input | DATA_W | Write word, one per cycle from the command cycle |
| wr_mask | input | DATA_W/8 | Byte mask for `wr_data`, 1 = do not write |
| dqs_oe | output | 1 | Strobe driver enable |
| dqs_toggle | output | 1 | Strobe edge on this beat (data capture beat) |
| dq_oe | output | 1 | Data driver enable; data lines high-impedance when 0 |
| dq_out | output | DATA_W | Data beat |
| dm_out | output | DATA_W/8 | Mask beat |
| cfg_err | output | 1 | Illegal latency setting seen on a command |

## Verification
Some rules are checked by assertions on every cycle:
- a new slot never starts before the running one has finished its eight beats;
- the first strobe edge of a run is always preceded by a driven, non-toggling cycle;
- the strobe stays driven for a cycle after its last edge;
- an idle strobe implies quiet data and mask lines;
- chopped beats carry an all-ones mask;
- the word store never overflows or underflows.

Other behaviour only the directed scenarios can show, because it needs cycle counts from the command. This covers the exact data latency for each additive latency code, the order and content of the data and mask words, seamless concatenation versus a one-cycle gap, a rejected early command, and the missing launch after an illegal setting.

// File: rtl/ddr_wr_pkg.sv
package ddr_wr_pkg;

  typedef enum logic [1:0] {
    AL_NONE   = 2'd0,
    AL_CWL_M1 = 2'd1,
    AL_CWL_M2 = 2'd2,
    AL_RSVD   = 2'd3
  } al_code_e;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_PRE  = 2'd1,
    PH_BEAT = 2'd2,
    PH_POST = 2'd3
  } phase_e;

endpackage

// File: rtl/wl_decode.sv
module wl_decode
  import ddr_wr_pkg::*;
#(
  parameter int CWL_W   = 4,
  parameter int WL_W    = 4,
  parameter int CWL_MIN = 5,
  parameter int CWL_MAX = 8
) (
  input  logic [CWL_W-1:0] cwl,
  input  logic [1:0]       al_sel,
  output logic [WL_W-1:0]  wl,
  output logic             ok
);

  localparam logic [CWL_W-1:0] CMIN = CWL_W'(CWL_MIN);
  localparam logic [CWL_W-1:0] CMAX = CWL_W'(CWL_MAX);

  logic [CWL_W-1:0] al;

  always_comb begin
    case (al_code_e'(al_sel))
      AL_CWL_M1: al = cwl - CWL_W'(1);
      AL_CWL_M2: al = cwl - CWL_W'(2);
      default:   al = '0;
    endcase
    wl = WL_W'(cwl) + WL_W'(al);
    ok = (cwl >= CMIN) && (cwl <= CMAX) && (al_code_e'(al_sel) != AL_RSVD);
  end

endmodule

// File: rtl/launch_sched.sv
module launch_sched #(
  parameter int BURST    = 8,
  parameter int WL_W     = 4,
  parameter int TL_DEPTH = 29
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_cmd,
  input  logic            cfg_ok,
  input  logic [WL_W-1:0] wl,
  input  logic            chop,
  output logic            cap_we,
  output logic            start,
  output logic            start_chop,
  output logic            pre_hint,
  output logic            cfg_err
);

  localparam int CNT_W = $clog2(BURST);
  localparam int IW    = $clog2(TL_DEPTH);

  logic [CNT_W-1:0]    cap_left;
  logic                accept;
  logic [IW-1:0]       ins_pos;
  logic [TL_DEPTH-1:0] tl_v, tl_c, hit_vec;

  assign accept  = wr_cmd && cfg_ok && (cap_left == '0);
  assign ins_pos = IW'(2 * wl - 2);
  assign cap_we  = accept || (cap_left != '0);

  always_comb begin
    hit_vec = '0;
    if (accept) hit_vec[ins_pos] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_left <= '0;
      tl_v     <= '0;
      tl_c     <= '0;
      cfg_err  <= 1'b0;
    end else begin
      if (accept)               cap_left <= CNT_W'(BURST - 1);
      else if (cap_left != '0)  cap_left <= cap_left - 1'b1;
      tl_v    <= (tl_v >> 1) | hit_vec;
      tl_c    <= ((tl_c >> 1) & ~hit_vec) | (chop ? hit_vec : '0);
      cfg_err <= wr_cmd && !cfg_ok;
    end
  end

  assign start      = tl_v[0];
  assign start_chop = tl_c[0];
  assign pre_hint   = tl_v[1] | tl_v[2];

  // R1: a token only enters a free timeline slot
  assert_slot_free_R1: assert property (@(posedge clk) disable iff (rst)
    accept |-> ((tl_v & hit_vec) == '0))
    else $error("timeline slot collision");

endmodule

// File: rtl/beat_store.sv
module beat_store #(
  parameter int W  = 18,
  parameter int AW = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we,
  input  logic [W-1:0] wdata,
  input  logic         re,
  output logic [W-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [AW:0]   fill;

  always_ff @(posedge clk) begin
    if (we) mem[wr_ptr] <= wdata;
  end

  assign rdata = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      fill   <= '0;
    end else begin
      if (we) wr_ptr <= wr_ptr + 1'b1;
      if (re) rd_ptr <= rd_ptr + 1'b1;
      case ({we, re})
        2'b10:   fill <= fill + 1'b1;
        2'b01:   fill <= fill - 1'b1;
        default: fill <= fill;
      endcase
    end
  end

  assert_fifo_no_overflow_R7: assert property (@(posedge clk) disable iff (rst)
    we |-> (fill < (AW+1)'(DEPTH)))
    else $error("beat store overflow");

  assert_fifo_no_underflow_R2: assert property (@(posedge clk) disable iff (rst)
    re |-> (fill != '0))
    else $error("beat store underflow");

endmodule

// File: rtl/slot_seq.sv
module slot_seq
  import ddr_wr_pkg::*;
#(
  parameter int BURST  = 8,
  parameter int DATA_W = 16,
  parameter int MASK_W = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     start,
  input  logic                     start_chop,
  input  logic                     pre_hint,
  input  logic [MASK_W+DATA_W-1:0] rd_word,
  output logic                     rd_en,
  output logic                     dqs_oe,
  output logic                     dqs_toggle,
  output logic                     dq_oe,
  output logic [DATA_W-1:0]        dq_out,
  output logic [MASK_W-1:0]        dm_out
);

  localparam int CNT_W = $clog2(BURST);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BURST - 1);
  localparam logic [CNT_W-1:0] HALF = CNT_W'(BURST / 2);

  logic             slot_on, chop_q;
  logic [CNT_W-1:0] cnt_q, nxt_cnt;
  logic             nxt_chop, last_beat, nxt_valid;
  phase_e           phase;

  always_comb begin
    nxt_cnt   = start ? '0 : cnt_q + 1'b1;
    nxt_chop  = start ? start_chop : chop_q;
    last_beat = slot_on && (cnt_q == LAST);
    if (start || (slot_on && !last_beat)) phase = PH_BEAT;
    else if (pre_hint)                    phase = PH_PRE;
    else if (last_beat)                   phase = PH_POST;
    else                                  phase = PH_IDLE;
    nxt_valid = (phase == PH_BEAT) && (!nxt_chop || (nxt_cnt < HALF));
  end

  assign rd_en = (phase == PH_BEAT);

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_on    <= 1'b0;
      cnt_q      <= '0;
      chop_q     <= 1'b0;
      dqs_oe     <= 1'b0;
      dqs_toggle <= 1'b0;
      dq_oe      <= 1'b0;
      dq_out     <= '0;
      dm_out     <= '0;
    end else begin
      slot_on    <= (phase == PH_BEAT);
      if (phase == PH_BEAT) cnt_q <= nxt_cnt;
      chop_q     <= nxt_chop;
      dqs_oe     <= (phase != PH_IDLE);
      dqs_toggle <= (phase == PH_BEAT);
      dq_oe      <= nxt_valid;
      dq_out     <= nxt_valid ? rd_word[DATA_W-1:0] : '0;
      dm_out     <= nxt_valid ? rd_word[MASK_W+DATA_W-1:DATA_W]
                              : ((phase == PH_BEAT) ? '1 : '0);
    end
  end

  assert_no_interrupt_R7: assert property (@(posedge clk) disable iff (rst)
    start |-> !(slot_on && (cnt_q != LAST)))
    else $error("new slot started inside a running burst");

  assert_preamble_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(dqs_toggle) |-> $past(dqs_oe))
    else $error("strobe edges without preamble");

  assert_postamble_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(dqs_toggle) |-> dqs_oe)
    else $error("strobe released without postamble");

  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    !dqs_oe |-> (!dq_oe && (dq_out == '0) && (dm_out == '0)))
    else $error("data lines active while idle");

  assert_chop_tail_R6: assert property (@(posedge clk) disable iff (rst)
    (dqs_toggle && !dq_oe) |-> (dm_out == '1))
    else $error("chopped beat not masked");

endmodule

// File: rtl/ddr3_wr_launcher.sv
module ddr3_wr_launcher #(
  parameter int DATA_W  = 16,
  parameter int BURST   = 8,
  parameter int CWL_W   = 4,
  parameter int CWL_MIN = 5,
  parameter int CWL_MAX = 8,
  parameter int FIFO_AW = 6
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [CWL_W-1:0]      cfg_cwl,
  input  logic [1:0]            cfg_al_sel,
  input  logic                  cfg_chop,
  input  logic                  wr_cmd,
  input  logic [DATA_W-1:0]     wr_data,
  input  logic [DATA_W/8-1:0]   wr_mask,
  output logic                  dqs_oe,
  output logic                  dqs_toggle,
  output logic                  dq_oe,
  output logic [DATA_W-1:0]     dq_out,
  output logic [DATA_W/8-1:0]   dm_out,
  output logic                  cfg_err
);

  localparam int MASK_W   = DATA_W / 8;
  localparam int WL_MAX   = 2 * CWL_MAX - 1;
  localparam int WL_W     = $clog2(WL_MAX + 1);
  localparam int TL_DEPTH = 2 * WL_MAX - 1;
  localparam int WORD_W   = MASK_W + DATA_W;

  logic [WL_W-1:0]   wl;
  logic              cfg_ok, cap_we, start, start_chop, pre_hint, rd_en;
  logic [WORD_W-1:0] rd_word;

  wl_decode #(
    .CWL_W(CWL_W), .WL_W(WL_W), .CWL_MIN(CWL_MIN), .CWL_MAX(CWL_MAX)
  ) u_wl (
    .cwl(cfg_cwl), .al_sel(cfg_al_sel), .wl(wl), .ok(cfg_ok)
  );

  launch_sched #(
    .BURST(BURST), .WL_W(WL_W), .TL_DEPTH(TL_DEPTH)
  ) u_sched (
    .clk(clk), .rst(rst), .wr_cmd(wr_cmd), .cfg_ok(cfg_ok), .wl(wl),
    .chop(cfg_chop), .cap_we(cap_we), .start(start), .start_chop(start_chop),
    .pre_hint(pre_hint), .cfg_err(cfg_err)
  );

  beat_store #(
    .W(WORD_W), .AW(FIFO_AW)
  ) u_store (
    .clk(clk), .rst(rst), .we(cap_we), .wdata({wr_mask, wr_data}),
    .re(rd_en), .rdata(rd_word)
  );

  slot_seq #(
    .BURST(BURST), .DATA_W(DATA_W), .MASK_W(MASK_W)
  ) u_seq (
    .clk(clk), .rst(rst), .start(start), .start_chop(start_chop),
    .pre_hint(pre_hint), .rd_word(rd_word), .rd_en(rd_en), .dqs_oe(dqs_oe),
    .dqs_toggle(dqs_toggle), .dq_oe(dq_oe), .dq_out(dq_out), .dm_out(dm_out)
  );

endmodule

// File: tb/ddr3_wr_launcher_tb.sv
module ddr3_wr_launcher_tb;

  localparam int LOGN = 4096;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  cfg_cwl = 4'd5;
  logic [1:0]  cfg_al_sel = 2'd0;
  logic        cfg_chop = 1'b0;
  logic        wr_cmd = 1'b0;
  logic [15:0] wr_data = '0;
  logic [1:0]  wr_mask = '0;
  logic        dqs_oe, dqs_toggle, dq_oe, cfg_err;
  logic [15:0] dq_out;
  logic [1:0]  dm_out;

  int cyc = 0;
  int tests = 0;
  int fails = 0;
  bit done = 0;

  logic        lg_oe [LOGN];
  logic        lg_tg [LOGN];
  logic        lg_dqoe [LOGN];
  logic [15:0] lg_dq [LOGN];
  logic [1:0]  lg_dm [LOGN];
  logic        lg_err [LOGN];

  ddr3_wr_launcher u_dut (
    .clk(clk), .rst(rst), .cfg_cwl(cfg_cwl), .cfg_al_sel(cfg_al_sel),
    .cfg_chop(cfg_chop), .wr_cmd(wr_cmd), .wr_data(wr_data), .wr_mask(wr_mask),
    .dqs_oe(dqs_oe), .dqs_toggle(dqs_toggle), .dq_oe(dq_oe), .dq_out(dq_out),
    .dm_out(dm_out), .cfg_err(cfg_err)
  );

  always #10 clk = ~clk;

  function automatic logic [15:0] fdat(int x);
    return 16'(x * 40503 + 4660);
  endfunction

  function automatic logic [1:0] fmsk(int x);
    return 2'(x ^ (x >> 2));
  endfunction

  function automatic int wl_of(int cwl, int al);
    if (al == 1) return 2 * cwl - 1;
    if (al == 2) return 2 * cwl - 2;
    return cwl;
  endfunction

  initial begin
    forever begin
      @(posedge clk);
      cyc = cyc + 1;
    end
  end

  // logger and data driver, both at the falling edge
  initial begin
    forever begin
      @(negedge clk);
      if (cyc < LOGN) begin
        lg_oe[cyc]   = dqs_oe;
        lg_tg[cyc]   = dqs_toggle;
        lg_dqoe[cyc] = dq_oe;
        lg_dq[cyc]   = dq_out;
        lg_dm[cyc]   = dm_out;
        lg_err[cyc]  = cfg_err;
      end
      wr_data = fdat(cyc);
      wr_mask = fmsk(cyc);
    end
  end

  task automatic check_at(input int idx, input bit oe, input bit tg, input bit dqoe,
                          input logic [15:0] dq, input logic [1:0] dm, input string tag);
    tests++;
    if (lg_oe[idx] !== oe || lg_tg[idx] !== tg || lg_dqoe[idx] !== dqoe ||
        lg_dq[idx] !== dq || lg_dm[idx] !== dm) begin
      fails++;
      $display("FAIL %s at cycle %0d: got oe=%0b tgl=%0b dqoe=%0b dq=%h dm=%b, expected oe=%0b tgl=%0b dqoe=%0b dq=%h dm=%b",
               tag, idx, lg_oe[idx], lg_tg[idx], lg_dqoe[idx], lg_dq[idx], lg_dm[idx],
               oe, tg, dqoe, dq, dm);
    end
  endtask

  task automatic check_err(input int idx, input bit exp, input string tag);
    tests++;
    if (lg_err[idx] !== exp) begin
      fails++;
      $display("FAIL %s at cycle %0d: got cfg_err=%0b, expected %0b", tag, idx, lg_err[idx], exp);
    end
  endtask

  task automatic check_burst(input int c, input int wl, input bit chop, input int npre,
                             input bit last, input string tag);
    int b = c + 2 * wl;
    bit v;
    if (npre == 2) check_at(b - 3, 0, 0, 0, 16'h0, 2'b00, {tag, " R3 idle before preamble"});
    for (int k = 1; k <= npre; k++)
      check_at(b - k, 1, 0, 0, 16'h0, 2'b00, {tag, " R3 preamble"});
    for (int j = 0; j < 8; j++) begin
      v = !chop || (j < 4);
      check_at(b + j, 1, 1, v, v ? fdat(c + j) : 16'h0, v ? fmsk(c + j) : 2'b11,
               {tag, " R1 R2 R5 R6 beat"});
    end
    if (last) begin
      check_at(b + 8, 1, 0, 0, 16'h0, 2'b00, {tag, " R4 postamble"});
      check_at(b + 9, 0, 0, 0, 16'h0, 2'b00, {tag, " R4 R8 idle after"});
    end
  endtask

  task automatic issue_at(input int at, input int cwl, input int al, input bit chop,
                          output int c);
    while (cyc < at) @(negedge clk);
    cfg_cwl = 4'(cwl);
    cfg_al_sel = 2'(al);
    cfg_chop = chop;
    wr_cmd = 1'b1;
    c = cyc;
    @(negedge clk);
    wr_cmd = 1'b0;
  endtask

  task automatic wait_to(input int at);
    while (cyc < at) @(negedge clk);
  endtask

  task automatic t_reset;
    tests++;
    if (dqs_oe !== 1'b0 || dqs_toggle !== 1'b0 || dq_oe !== 1'b0 || dq_out !== 16'h0 ||
        dm_out !== 2'b00 || cfg_err !== 1'b0) begin
      fails++;
      $display("FAIL R11 reset: got oe=%0b tgl=%0b dqoe=%0b dq=%h dm=%b err=%0b, expected all 0",
               dqs_oe, dqs_toggle, dq_oe, dq_out, dm_out, cfg_err);
    end
  endtask

  task automatic t_single(input int cwl, input int al, input bit chop, input string tag);
    int c;
    int wl = wl_of(cwl, al);
    issue_at(cyc + 2, cwl, al, chop, c);
    wait_to(c + 2 * wl + 14);
    check_burst(c, wl, chop, 2, 1, tag);
  endtask

  task automatic t_concat;
    int c1, c2;
    issue_at(cyc + 2, 5, 0, 0, c1);
    issue_at(c1 + 8, 5, 0, 0, c2);
    wait_to(c2 + 24);
    check_burst(c1, 5, 0, 2, 0, "R9 concat first");
    check_burst(c2, 5, 0, 0, 1, "R9 concat second");
  endtask

  task automatic t_gap;
    int c1, c2;
    issue_at(cyc + 2, 6, 0, 0, c1);
    issue_at(c1 + 9, 6, 0, 0, c2);
    wait_to(c2 + 26);
    check_burst(c1, 6, 0, 2, 0, "R3 gap first");
    check_burst(c2, 6, 0, 1, 1, "R3 gap second");
  endtask

  task automatic t_early;
    int c1, c2;
    int b;
    issue_at(cyc + 2, 5, 0, 0, c1);
    issue_at(c1 + 4, 5, 0, 0, c2);
    wait_to(c2 + 24);
    b = c1 + 10;
    check_burst(c1, 5, 0, 2, 1, "R7 early cmd ignored");
    for (int k = 10; k < 14; k++)
      check_at(b + k, 0, 0, 0, 16'h0, 2'b00, "R7 R8 no second burst");
  endtask

  task automatic t_illegal(input int cwl, input int al, input string tag);
    int c;
    bit quiet = 1;
    issue_at(cyc + 2, cwl, al, 0, c);
    wait_to(c + 40);
    check_err(c + 1, 1, {tag, " R10 error pulse"});
    check_err(c + 2, 0, {tag, " R10 error single cycle"});
    for (int k = 0; k < 38; k++) if (lg_oe[c + k] !== 1'b0) quiet = 0;
    tests++;
    if (!quiet) begin
      fails++;
      $display("FAIL %s R10 launch: got strobe driven, expected none", tag);
    end
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_single(5, 0, 0, "R1 basic wl5");
    t_single(6, 1, 0, "R1 al cwl-1");
    t_single(8, 2, 0, "R1 al cwl-2");
    t_single(7, 0, 1, "R6 chop");
    t_concat();
    t_gap();
    t_early();
    t_illegal(4, 0, "cwl low");
    t_illegal(6, 3, "al reserved");
    t_single(5, 2, 0, "R1 after error");
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: got no completion, expected end of scenarios");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule